// File: doc/BRIEF.md
# Directed Rounding Result Fixup

This block repairs results from an arithmetic datapath that can only round to nearest or toward zero. When the rounding mode asks for rounding toward plus or minus infinity, the block takes the truncated result and moves it one step. A float result is adjusted on its sign-magnitude bit pattern. An integer or fractional conversion result is adjusted on its two's-complement value. The result is 64 bits, held as an upper and a lower word. Each word has its own inexact flag. The block also receives the sign bits of the source operand's two words, which are needed when a signed conversion produced zero.

The result can be one single-precision value in the lower word, one double-precision value that spans both words, or a pair of single-precision values with one in each word. For a double-precision integer conversion, only the lower word is changed. The corrected result appears one clock cycle after the inputs.

Top module: `dirround_fixup`

## Requirements
- R1: No adjustment is made unless `inexact_lo` is 1, or unless `fmt` is 2 (paired) and `inexact_hi` is 1. In single and double formats, `inexact_hi` alone has no effect.
- R2: With `op_class` 3 (conversion that always truncates toward zero), the result passes unchanged.
- R3: With `op_class` 1 (unsigned integer or fraction conversion), every word is treated as positive, whatever its top bit.
- R4: With `op_class` 2 (signed conversion), a result word equal to zero takes its sign from the matching source sign input. In double format, the deciding sign is the lower result word's top bit, or `src_sign_hi` when the lower word is zero.
- R5: In single format (`fmt` 0), only the lower word changes, and it wraps within its own width. For `rnd_mode` 2 (toward plus infinity), a positive word is incremented. For `rnd_mode` 3 (toward minus infinity), a negative word is incremented if `op_class` is 0 (float) and decremented otherwise.
- R6: In double format (`fmt` 1), the sign comes from the upper word. A float result is incremented as one 64-bit value, so a carry crosses into the upper word. An integer result changes only the lower word.
- R7: In paired format (`fmt` 2), each word is adjusted independently, using its own sign and its own inexact flag. A carry never crosses between the words.
- R8: With `rnd_mode` 0 (nearest) or 1 (toward zero), the result passes unchanged.
- R9: `res_out` is registered: it shows the result of the inputs sampled at the previous rising edge, and it is zero while `rst_n` is low.
- R10: Format code 3 is reserved, and the result passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_in | input | 2*W | Truncated result, upper word in the top half |
| src_sign_hi | input | 1 | Sign bit of the source operand's upper word |
| src_sign_lo | input | 1 | Sign bit of the source operand's lower word |
| inexact_hi | input | 1 | Upper word result is inexact |
| inexact_lo | input | 1 | Lower word result is inexact |
| rnd_mode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| fmt | input | 2 | 0 single, 1 double, 2 paired single, 3 reserved |
| op_class | input | 2 | 0 float, 1 unsigned conversion, 2 signed conversion, 3 truncating conversion |
| res_out | output | 2*W | Corrected result |

## Verification
The bench builds the block with `W` = 4, which makes the result 8 bits wide. At that width, every result pattern can be swept against every mode, format, class, inexact pair and source sign pair. This exposes the corner cases completely:
- a word wrapping from all ones to zero;
- an all-zero word taking its sign from the source;
- a double-precision carry crossing from the lower word into the upper word, next to the paired format, where no carry crosses.

// File: rtl/dirround_fixup.sv
module dirround_fixup #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*W-1:0] res_in,
  input  logic           src_sign_hi,
  input  logic           src_sign_lo,
  input  logic           inexact_hi,
  input  logic           inexact_lo,
  input  logic [1:0]     rnd_mode,
  input  logic [1:0]     fmt,
  input  logic [1:0]     op_class,
  output logic [2*W-1:0] res_out
);
  localparam int D = 2 * W;

  wire [W-1:0] lo_w = res_in[W-1:0];
  wire [W-1:0] hi_w = res_in[D-1:W];

  wire to_pinf  = (rnd_mode == 2'd2);
  wire directed = rnd_mode[1];
  wire is_flt   = (op_class == 2'd0);
  wire is_uns   = (op_class == 2'd1);
  wire is_sgn   = (op_class == 2'd2);
  wire is_trz   = (op_class == 2'd3);

  wire en_lo = directed && !is_trz && inexact_lo;
  wire en_hi = directed && !is_trz && inexact_hi;

  logic s_lo, s_hi;
  always_comb begin
    s_lo = lo_w[W-1];
    s_hi = hi_w[W-1];
    if (is_uns) begin
      s_lo = 1'b0;
      s_hi = 1'b0;
    end else if (is_sgn) begin
      if (fmt == 2'd1) begin
        s_hi = (lo_w == '0) ? src_sign_hi : lo_w[W-1];
      end else begin
        if (lo_w == '0) s_lo = src_sign_lo;
        if (hi_w == '0) s_hi = src_sign_hi;
      end
    end
  end

  function automatic logic [W-1:0] adj(input logic [W-1:0] v, input logic sgn,
                                       input logic en, input logic pinf, input logic flt);
    logic up, dn;
    up = en && (pinf ? !sgn : (sgn && flt));
    dn = en && !pinf && sgn && !flt;
    if (up)      adj = v + 1'b1;
    else if (dn) adj = v - 1'b1;
    else         adj = v;
  endfunction

  wire dbl_up = en_lo && (to_pinf ? !s_hi : s_hi);

  logic [D-1:0] fixed;
  always_comb begin
    case (fmt)
      2'd0: fixed = {hi_w, adj(lo_w, s_lo, en_lo, to_pinf, is_flt)};
      2'd1: fixed = is_flt ? (dbl_up ? res_in + 1'b1 : res_in)
                           : {hi_w, adj(lo_w, s_hi, en_lo, to_pinf, 1'b0)};
      2'd2: fixed = {adj(hi_w, s_hi, en_hi, to_pinf, is_flt),
                     adj(lo_w, s_lo, en_lo, to_pinf, is_flt)};
      default: fixed = res_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_out <= '0;
    else        res_out <= fixed;
  end
endmodule

// File: rtl/dirround_fixup_chk.sv
module dirround_fixup_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*W-1:0] res_in,
  input logic           inexact_hi,
  input logic           inexact_lo,
  input logic [1:0]     rnd_mode,
  input logic [1:0]     fmt,
  input logic [1:0]     op_class,
  input logic [2*W-1:0] res_out
);
  p_no_inexact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inexact_lo && !(fmt == 2'd2 && inexact_hi)) |=> res_out == $past(res_in));

  p_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'd3) |=> res_out == $past(res_in));

  p_dbl_int_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd1 && op_class != 2'd0) |=> res_out[2*W-1:W] == $past(res_in[2*W-1:W]));

  p_single_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd0) |=> res_out[2*W-1:W] == $past(res_in[2*W-1:W]));

  p_vec_hi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd2 && !inexact_hi) |=> res_out[2*W-1:W] == $past(res_in[2*W-1:W]));

  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rnd_mode[1]) |=> res_out == $past(res_in));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd3) |=> res_out == $past(res_in));

  always @(posedge clk)
    if (!rst_n) p_reset_r9: assert (res_out == '0);
endmodule

bind dirround_fixup dirround_fixup_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_in(res_in), .inexact_hi(inexact_hi),
  .inexact_lo(inexact_lo), .rnd_mode(rnd_mode), .fmt(fmt),
  .op_class(op_class), .res_out(res_out)
);

// File: tb/dirround_fixup_test.sv
module dirround_fixup_test;
  localparam int W = 4;
  localparam int D = 2 * W;
  localparam int M = 1 << W;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [D-1:0] res_in = '0;
  logic         src_sign_hi = 0, src_sign_lo = 0, inexact_hi = 0, inexact_lo = 0;
  logic [1:0]   rnd_mode = 0, fmt = 0, op_class = 0;
  logic [D-1:0] res_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dirround_fixup #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .res_in(res_in), .src_sign_hi(src_sign_hi),
    .src_sign_lo(src_sign_lo), .inexact_hi(inexact_hi), .inexact_lo(inexact_lo),
    .rnd_mode(rnd_mode), .fmt(fmt), .op_class(op_class), .res_out(res_out)
  );

  function automatic int step(int v, bit neg, bit pinf, bit flt, int mod);
    if (pinf) return neg ? v : (v + 1) % mod;
    if (!neg) return v;
    return flt ? (v + 1) % mod : (v + mod - 1) % mod;
  endfunction

  function automatic int expect_val(int r, bit ssh, bit ssl, bit ih, bit il,
                                    int m, int f, int c);
    int lo, hi, nl, nh;
    bit neg_lo, neg_hi, pinf, flt;
    lo = r % M; hi = r / M;
    if (m < 2 || f == 3 || c == 3) return r;
    pinf = (m == 2); flt = (c == 0);
    neg_lo = (lo >= M / 2); neg_hi = (hi >= M / 2);
    if (c == 1) begin neg_lo = 0; neg_hi = 0; end
    if (c == 2) begin
      if (f == 1) neg_hi = (lo == 0) ? ssh : (lo >= M / 2);
      else begin
        if (lo == 0) neg_lo = ssl;
        if (hi == 0) neg_hi = ssh;
      end
    end
    nl = lo; nh = hi;
    if (f == 0) begin
      if (il) nl = step(lo, neg_lo, pinf, flt, M);
    end else if (f == 1) begin
      if (il) begin
        if (flt) return step(r, neg_hi, pinf, 1'b1, M * M);
        nl = step(lo, neg_hi, pinf, 1'b0, M);
      end
    end else begin
      if (il) nl = step(lo, neg_lo, pinf, flt, M);
      if (ih) nh = step(hi, neg_hi, pinf, flt, M);
    end
    return nh * M + nl;
  endfunction

  function automatic string tag_of(int m, int f, int c, bit ih, bit il);
    if (m < 2) return "R8";
    if (f == 3) return "R10";
    if (!il && !(f == 2 && ih)) return "R1";
    if (c == 3) return "R2";
    if (c == 1) return "R3";
    if (c == 2) return "R4";
    if (f == 2) return "R7";
    if (f == 1) return "R6";
    return "R5";
  endfunction

  task automatic check(string tag, logic [D-1:0] got, logic [D-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s res_in=%h mode=%0d fmt=%0d cls=%0d inx=%b%b ss=%b%b got=%h exp=%h",
               tag, res_in, rnd_mode, fmt, op_class, inexact_hi, inexact_lo,
               src_sign_hi, src_sign_lo, got, exp);
    end
  endtask

  task automatic apply(int r, bit ssh, bit ssl, bit ih, bit il, int m, int f, int c);
    @(negedge clk);
    res_in = r[D-1:0]; src_sign_hi = ssh; src_sign_lo = ssl;
    inexact_hi = ih; inexact_lo = il;
    rnd_mode = m[1:0]; fmt = f[1:0]; op_class = c[1:0];
    @(posedge clk); #5;
    check(tag_of(m, f, c, ih, il), res_out,
          expect_val(r, ssh, ssl, ih, il, m, f, c)[D-1:0]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 check("R9", res_out, '0);
    res_in = 8'h37; rnd_mode = 2; inexact_lo = 1;
    @(posedge clk); #5 check("R9", res_out, '0);
    @(negedge clk) rst_n = 1;
    apply(8'h25, 0, 0, 0, 1, 2, 0, 0);
    @(negedge clk);
    res_in = 8'h90; fmt = 1; op_class = 0; rnd_mode = 3; inexact_lo = 1;
    #2 check("R9", res_out, 8'h26);
    @(posedge clk); #5 check("R9", res_out, 8'h91);
    apply(8'h1F, 0, 0, 0, 1, 2, 1, 0); // R6 carry across words
    apply(8'h1F, 0, 0, 1, 1, 2, 2, 0); // R7 no carry
    apply(8'h70, 1, 1, 0, 1, 3, 0, 2); // R4 zero takes source sign
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 4; f++)
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < M * M; r++)
            apply(r, 1, 1, 1, 1, m, f, c);
    for (int m = 2; m < 4; m++)
      for (int f = 0; f < 4; f++)
        for (int c = 0; c < 4; c++)
          for (int x = 0; x < 4; x++)
            for (int s = 0; s < 4; s++)
              for (int r = 0; r < M * M; r++)
                apply(r, s[1], s[0], x[1], x[0], m, f, c);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule